// File: doc/BRIEF.md
# Parallel 2x2 Average Pooling Unit

The unit shrinks a square greyscale image by averaging every non-overlapping 2x2 block of pixels. With the default sizes, a 28x28 image of 8-bit pixels becomes a 14x14 map. The image is first written into an internal frame store as 32-bit words, each carrying four neighbouring pixels of one row. The writer then pulses `start`. From that point the unit owns the frame store until the last result has left.

The pooling pass takes one pair of image rows at a time. A bank of seven averaging clusters works in parallel. Each cluster takes the four pixels of one 2x2 block. One round fills the left half of the pair's output row, and the next round fills the right half, so each clock cycle yields seven pooled pixels. The result stream is in row-major order. Each beat carries a flat output index for its first pixel. A one-cycle completion pulse follows the final beat.

Top module: `pool2x2_unit`

## Requirements
- R1: A write of `wr_data` to word address a (0 to 195) stores byte lane j (bits 8j+7 down to 8j, j = 0..3) as the pixel at row a/7, column 4*(a%7)+j.
- R2: Each pooled pixel equals the sum of its four source pixels divided by four with the remainder dropped. Four pixels of 255 give 255.
- R3: When `start` is sampled high while idle, the first result beat is valid on the next clock edge. Exactly 28 consecutive valid beats follow. With no `start`, no beat is ever valid.
- R4: Each valid beat carries seven pooled pixels, lane k in bits 8k+7 down to 8k. `out_idx` is the flat index (output row times 14 plus output column) of lane 0. It is 0 on the first beat and rises by 7 on each following beat.
- R5: Beat n (counting from 0) covers source rows 2*(n/2) and 2*(n/2)+1. An even beat covers source columns 0 to 13, and an odd beat covers source columns 14 to 27.
- R6: `done` is high for exactly one cycle, one cycle after the last valid beat, and `out_valid` is low in that cycle.
- R7: While a pass is running, `start` pulses and frame-store writes have no effect: the pass continues in order, and the stored image is unchanged.
- R8: While reset is asserted and right after it, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Frame-store word write strobe |
| wr_addr | input | 8 | Word address, 0 to 195 |
| wr_data | input | 32 | Four packed pixels, lane 0 in the low byte |
| start | input | 1 | Begins a pooling pass when idle |
| out_valid | output | 1 | Result beat is valid |
| out_idx | output | 8 | Flat output index of lane 0 |
| out_pix | output | 56 | Seven pooled pixels, lane 0 in the low byte |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
All results are registered once. The beat for round n is due n+1 edges after the edge that samples `start`, and `done` is due one edge after the last beat. The bench drives stimulus on the falling edge. It then counts falling edges: one idle edge after releasing `start`, then one beat per edge, then the completion edge. Each value is compared at the falling edge that follows the rising edge where it is due. Writes and `start` pulses injected mid-pass are checked through the order of the running stream and through a clean rerun that must reproduce the original image.

// File: rtl/pool_pkg.sv
package pool_pkg;
    localparam int DEF_IMG_DIM  = 28;
    localparam int DEF_PIX_W    = 8;
    localparam int DEF_LANES    = 4;
    localparam int DEF_CLUSTERS = 7;

    typedef enum logic [0:0] {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/pool_cluster.sv
module pool_cluster #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] px_a,
    input  logic [PIX_W-1:0] px_b,
    input  logic [PIX_W-1:0] px_c,
    input  logic [PIX_W-1:0] px_d,
    output logic [PIX_W-1:0] avg
);
    localparam int SUM_W = PIX_W + 2;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(px_a) + SUM_W'(px_b) + SUM_W'(px_c) + SUM_W'(px_d);
        avg = sum[SUM_W-1:2];
    end
endmodule

// File: rtl/pool_framebuf.sv
module pool_framebuf #(
    parameter int IMG_DIM  = 28,
    parameter int PIX_W    = 8,
    parameter int LANES    = 4,
    parameter int CLUSTERS = 7,
    parameter int ADDR_W   = 8,
    parameter int PAIR_W   = 4,
    parameter int RND_W    = 1
) (
    input  logic                            clk,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [LANES*PIX_W-1:0]          wr_data,
    input  logic [PAIR_W-1:0]               pair,
    input  logic [RND_W-1:0]                half,
    output logic [2*CLUSTERS*PIX_W-1:0]     upper_row,
    output logic [2*CLUSTERS*PIX_W-1:0]     lower_row
);
    localparam int ROW_W   = $clog2(IMG_DIM);
    localparam int WPR     = IMG_DIM / LANES;
    localparam int N_WORDS = IMG_DIM * WPR;
    localparam int SPAN    = 2 * CLUSTERS;

    logic [PIX_W-1:0] mem_q [IMG_DIM][IMG_DIM];
    logic [ROW_W-1:0] wr_row;
    logic [ROW_W-1:0] wr_col0;
    logic             wr_ok;
    logic [ROW_W-1:0] rd_row0;
    logic [ROW_W-1:0] rd_row1;

    always_comb begin
        wr_ok   = wr_en && (int'(wr_addr) < N_WORDS);
        wr_row  = ROW_W'(int'(wr_addr) / WPR);
        wr_col0 = ROW_W'((int'(wr_addr) % WPR) * LANES);
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            for (int j = 0; j < LANES; j++) begin
                mem_q[wr_row][wr_col0 + ROW_W'(j)] <= wr_data[j*PIX_W +: PIX_W];
            end
        end
    end

    always_comb begin
        rd_row0 = ROW_W'(int'(pair) * 2);
        rd_row1 = ROW_W'(int'(pair) * 2 + 1);
    end

    for (genvar i = 0; i < SPAN; i++) begin : g_col
        logic [ROW_W-1:0] rd_col;
        always_comb begin
            rd_col = ROW_W'(int'(half) * SPAN + i);
            upper_row[i*PIX_W +: PIX_W] = mem_q[rd_row0][rd_col];
            lower_row[i*PIX_W +: PIX_W] = mem_q[rd_row1][rd_col];
        end
    end
endmodule

// File: rtl/pool_sequencer.sv
module pool_sequencer
    import pool_pkg::*;
#(
    parameter int OUT_DIM = 14,
    parameter int ROUNDS  = 2,
    parameter int PAIR_W  = 4,
    parameter int RND_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              active,
    output logic              last_round,
    output logic [PAIR_W-1:0] pair,
    output logic [RND_W-1:0]  half
);
    typedef struct packed {
        seq_mode_e         mode;
        logic [PAIR_W-1:0] pair;
        logic [RND_W-1:0]  half;
    } seq_s;

    seq_s st_d, st_q;
    logic half_end;
    logic pair_end;

    always_comb begin
        half_end   = (st_q.half == RND_W'(ROUNDS - 1));
        pair_end   = (st_q.pair == PAIR_W'(OUT_DIM - 1));
        st_d       = st_q;
        case (st_q.mode)
            MODE_IDLE: begin
                if (start) begin
                    st_d.mode = MODE_RUN;
                    st_d.pair = '0;
                    st_d.half = '0;
                end
            end
            default: begin
                if (half_end) begin
                    st_d.half = '0;
                    if (pair_end) begin
                        st_d.mode = MODE_IDLE;
                        st_d.pair = '0;
                    end else begin
                        st_d.pair = st_q.pair + 1'b1;
                    end
                end else begin
                    st_d.half = st_q.half + 1'b1;
                end
            end
        endcase
        active     = (st_q.mode == MODE_RUN);
        last_round = active && half_end && pair_end;
        pair       = st_q.pair;
        half       = st_q.half;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, pair: '0, half: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.pair) < OUT_DIM);  // R5
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last_round) |=> active);  // R7
    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !active);  // R3
endmodule

// File: rtl/pool2x2_unit.sv
module pool2x2_unit
    import pool_pkg::*;
#(
    parameter int IMG_DIM  = DEF_IMG_DIM,
    parameter int PIX_W    = DEF_PIX_W,
    parameter int LANES    = DEF_LANES,
    parameter int CLUSTERS = DEF_CLUSTERS,
    localparam int OUT_DIM = IMG_DIM / 2,
    localparam int N_OUT   = OUT_DIM * OUT_DIM,
    localparam int N_WORDS = IMG_DIM * IMG_DIM / LANES,
    localparam int ADDR_W  = $clog2(N_WORDS),
    localparam int IDX_W   = $clog2(N_OUT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*PIX_W-1:0]    wr_data,
    input  logic                      start,
    output logic                      out_valid,
    output logic [IDX_W-1:0]          out_idx,
    output logic [CLUSTERS*PIX_W-1:0] out_pix,
    output logic                      done
);
    localparam int ROUNDS   = IMG_DIM / (2 * CLUSTERS);
    localparam int RND_W    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam int PAIR_W   = (OUT_DIM > 1) ? $clog2(OUT_DIM) : 1;
    localparam int SPAN     = 2 * CLUSTERS;
    localparam int LAST_IDX = N_OUT - CLUSTERS;

    typedef struct packed {
        logic                      valid;
        logic [IDX_W-1:0]          idx;
        logic [CLUSTERS*PIX_W-1:0] pix;
        logic                      done;
    } out_s;

    out_s o_d, o_q;

    logic                  active;
    logic                  last_round;
    logic [PAIR_W-1:0]     pair;
    logic [RND_W-1:0]      half;
    logic [SPAN*PIX_W-1:0] upper_row;
    logic [SPAN*PIX_W-1:0] lower_row;
    logic [CLUSTERS*PIX_W-1:0] avg_all;
    logic                  wr_gated;

    assign wr_gated = wr_en && !active;

    pool_sequencer #(
        .OUT_DIM (OUT_DIM),
        .ROUNDS  (ROUNDS),
        .PAIR_W  (PAIR_W),
        .RND_W   (RND_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .active     (active),
        .last_round (last_round),
        .pair       (pair),
        .half       (half)
    );

    pool_framebuf #(
        .IMG_DIM  (IMG_DIM),
        .PIX_W    (PIX_W),
        .LANES    (LANES),
        .CLUSTERS (CLUSTERS),
        .ADDR_W   (ADDR_W),
        .PAIR_W   (PAIR_W),
        .RND_W    (RND_W)
    ) u_buf (
        .clk       (clk),
        .wr_en     (wr_gated),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pair      (pair),
        .half      (half),
        .upper_row (upper_row),
        .lower_row (lower_row)
    );

    for (genvar k = 0; k < CLUSTERS; k++) begin : g_cluster
        pool_cluster #(.PIX_W(PIX_W)) u_cl (
            .px_a (upper_row[(2*k)*PIX_W   +: PIX_W]),
            .px_b (upper_row[(2*k+1)*PIX_W +: PIX_W]),
            .px_c (lower_row[(2*k)*PIX_W   +: PIX_W]),
            .px_d (lower_row[(2*k+1)*PIX_W +: PIX_W]),
            .avg  (avg_all[k*PIX_W +: PIX_W])
        );
    end

    always_comb begin
        o_d.valid = active;
        o_d.idx   = IDX_W'(int'(pair) * OUT_DIM + int'(half) * CLUSTERS);
        o_d.pix   = active ? avg_all : o_q.pix;
        o_d.done  = o_q.valid && (o_q.idx == IDX_W'(LAST_IDX)) && !active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_idx   = o_q.idx;
    assign out_pix   = o_q.pix;
    assign done      = o_q.done;

    AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == '0));  // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) + IDX_W'(CLUSTERS)));  // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && $past(out_idx) == IDX_W'(LAST_IDX)));  // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);  // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6
    AST_LAST_FEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        last_round |=> ##1 done);  // R6
endmodule

// File: tb/sim_pool2x2_unit.sv
`timescale 1ns/1ps
module sim_pool2x2_unit;
    localparam int DIM   = 28;
    localparam int ODIM  = 14;
    localparam int NCL   = 7;
    localparam int BEATS = 28;

    // pattern table: pixel(r,c) = (ca*r + cb*c + c0) & 255
    localparam int N_PAT = 5;
    localparam int PAT [N_PAT][3] = '{
        '{0,   0,   255},
        '{1,   1,   0},
        '{29,  7,   3},
        '{37,  113, 200},
        '{0,   0,   0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic        out_valid;
    logic [7:0]  out_idx;
    logic [55:0] out_pix;
    logic        done;

    int total = 0;
    int bad   = 0;
    int img [DIM][DIM];

    always #2.5 clk = ~clk;

    pool2x2_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .start     (start),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_pix   (out_pix),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // R1: word a -> row a/7, columns 4*(a%7)+j from byte lane j
    task automatic fill(input int ca, input int cb, input int c0);
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++)
                img[r][c] = (ca * r + cb * c + c0) & 255;
        for (int a = 0; a < DIM * DIM / 4; a++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 8'(a);
            for (int j = 0; j < 4; j++)
                wr_data[j*8 +: 8] = 8'(img[a / 7][4 * (a % 7) + j]);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [55:0] exp_beat(input int n);
        logic [55:0] v;
        int orow, ocol, s;
        v = '0;
        for (int k = 0; k < NCL; k++) begin
            orow = n / 2;
            ocol = (n % 2) * NCL + k;
            s = img[2*orow][2*ocol] + img[2*orow][2*ocol+1]
              + img[2*orow+1][2*ocol] + img[2*orow+1][2*ocol+1];
            v[k*8 +: 8] = 8'(s / 4);
        end
        return v;
    endfunction

    task automatic run_pool(input bit disturb);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!out_valid, "R3 not yet valid", 64'(out_valid), 64'd0);
        for (int n = 0; n < BEATS; n++) begin
            @(negedge clk);
            if (disturb && n == 5) begin
                start = 1'b0;
                wr_en = 1'b0;
            end
            chk(out_valid && out_idx == 8'(n * NCL), "R3/R4/R7 beat valid+index",
                {55'd0, out_valid, out_idx}, {55'd1, 8'(n * NCL)});
            chk(out_pix == exp_beat(n), "R2/R5 pooled pixels",
                64'(out_pix), 64'(exp_beat(n)));
            if (disturb && n == 4) begin
                start   = 1'b1;
                wr_en   = 1'b1;
                wr_addr = 8'd0;
                wr_data = 32'hFFFF_FFFF;
            end
        end
        @(negedge clk);
        chk(done && !out_valid, "R6 done after last beat", {out_valid, done}, 2'b01);
        @(negedge clk);
        chk(!done && !out_valid, "R6 done single pulse", {out_valid, done}, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !done, "R8 reset outputs", {out_valid, done}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done, "R8 after reset", {out_valid, done}, 2'b00);

        // R3: no start, no beats
        fill(1, 2, 9);
        repeat (4) begin
            @(negedge clk);
            chk(!out_valid && !done, "R3 idle without start", {out_valid, done}, 2'b00);
        end

        // table walk
        for (int p = 0; p < N_PAT; p++) begin
            fill(PAT[p][0], PAT[p][1], PAT[p][2]);
            run_pool(1'b0);
        end

        // R7: start and writes mid-pass ignored, image intact on rerun
        fill(41, 3, 17);
        run_pool(1'b1);
        run_pool(1'b0);

        // R2: rounding-down corner, sum 1+1+1+2 = 5 -> 1
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++)
                img[r][c] = ((r % 2) == 1 && (c % 2) == 1) ? 2 : 1;
        for (int a = 0; a < DIM * DIM / 4; a++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 8'(a);
            wr_data = ((a / 7) % 2 == 1) ? 32'h0201_0201 : 32'h0101_0101;
        end
        @(negedge clk);
        wr_en = 1'b0;
        run_pool(1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule